// File: doc/BRIEF.md
# Single-Wire Debug Bus Bridge

This block gives an external debugger read and write access to three internal address spaces over one shared serial line. The line carries asynchronous characters: one start bit, eight data bits sent least significant bit first, one stop bit and no parity. The debugger sends a command character, an optional block length, a four-byte address and, for writes, the data bytes. The bridge turns every data byte into one access on a byte-wide request/acknowledge bus. For a read it turns the line around, drives the requested bytes back, then lets go of the line.

The bit period is set at run time through `baud_div`, the number of system clocks per bit. At a 50 MHz clock a value of 50 gives one megabaud. A block access steps the address up by one for each byte. A block may carry 1 to 64 bytes. A fourth space code is reserved: it is parsed like any other command but never reaches the bus.

Top module: `dwb_wire_bridge`

## Requirements
- R1: Every character is one low start bit, eight data bits least significant bit first and one high stop bit. Each bit lasts `baud_div` clocks. The receiver confirms a start bit by sampling it again at mid-bit.
- R2: A received character whose stop bit is low is discarded. The receiver does not start a new character until the line has returned high.
- R3: In the command character, bit 7 selects read (1) or write (0). Bits 6:5 select the size: 00 is one byte, 01 two bytes, 10 four bytes, 11 a block. Bits 4:3 select the space: 00 peripheral, 01 data memory, 10 program memory, 11 reserved. Bits 2:0 are ignored.
- R4: For a block, the character after the command gives the length in its bits 5:0. The value 0 means 64 and bits 7:6 are ignored.
- R5: The address follows as four characters, least significant first. Data bytes also travel least significant first. Byte i of a transfer is one bus access at address+i.
- R6: A bus access holds `bus_req` with its address, direction, space and write data stable until `bus_ack`. One acknowledge completes exactly one access.
- R7: A read returns one character per requested byte, in address order, carrying the value the bus returned.
- R8: For a read, the bridge starts driving the line no sooner than one bit period and no later than two bit periods after the end of the last received stop bit.
- R9: Once it starts driving, the bridge drives the line without a break until the final stop bit of the reply is complete. It releases the line within one bit period after that. It never drives the line during a write.
- R10: A command to the reserved space makes no bus access. A read of the reserved space returns 0x00 for every requested byte.
- R11: A write data character may complete while the previous byte's write still waits for its acknowledge. That character is kept and written next, in order.
- R12: After reset the line is released, `pin_out` is high and no bus access is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | 16 | System clocks per bit |
| pin_in | input | 1 | Level seen on the shared serial line |
| pin_out | output | 1 | Level the bridge drives when it owns the line |
| pin_oe | output | 1 | High while the bridge drives the line |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_space | output | 2 | Target space, coded as in R3 |
| bus_addr | output | 32 | Byte address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, taken when `bus_ack` is high |
| bus_ack | input | 1 | Completes the pending access |

## Verification
Two events can land on the same clock edge: a received write character becomes valid, and the acknowledge for the previous byte's write arrives. The bench provokes this with four-byte block writes sent back to back. It sweeps the slave's acknowledge latency over a window of cycles centred on one character time, so that the acknowledge falls just before, exactly on, and just after the moment the next character completes. The reference model queues the expected accesses in order, and every acknowledged access is compared against the head of that queue. A lost, repeated or reordered byte therefore shows up as a mismatch or as a non-empty queue at the end of the transfer.

// File: rtl/dwb_pkg.sv
package dwb_pkg;

  typedef enum logic [1:0] {
    SP_PERIPH = 2'b00,
    SP_DATA   = 2'b01,
    SP_PROG   = 2'b10,
    SP_RSVD   = 2'b11
  } space_e;

  typedef enum logic [1:0] {
    SZ_ONE  = 2'b00,
    SZ_TWO  = 2'b01,
    SZ_FOUR = 2'b10,
    SZ_BLK  = 2'b11
  } size_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BREAK
  } rx_state_e;

  typedef enum logic [2:0] {
    SQ_CMD,
    SQ_LEN,
    SQ_ADDR,
    SQ_WDAT,
    SQ_WBUS,
    SQ_TURN,
    SQ_RBUS,
    SQ_TX
  } seq_state_e;

endpackage

// File: rtl/dwb_uart_rx.sv
module dwb_uart_rx
  import dwb_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             line_i,
  output logic             vld_o,
  output logic [7:0]       data_o
);

  logic [SYNC_N-1:0] sync_q;
  logic              s_line;
  rx_state_e         st_q, st_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [2:0]        bit_q, bit_d;
  logic [7:0]        sh_q, sh_d;
  logic              vld_d;
  logic [DIV_W-1:0]  half;
  logic [DIV_W-1:0]  last;

  assign s_line = sync_q[SYNC_N-1];
  assign half   = div >> 1;
  assign last   = div - DIV_W'(1);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    vld_d = 1'b0;
    case (st_q)
      RX_IDLE: begin
        if (!s_line) begin
          st_d  = RX_START;
          cnt_d = '0;
        end
      end
      RX_START: begin
        if (cnt_q == half) begin
          cnt_d = '0;
          bit_d = '0;
          st_d  = s_line ? RX_IDLE : RX_DATA;
        end else begin
          cnt_d = cnt_q + DIV_W'(1);
        end
      end
      RX_DATA: begin
        if (cnt_q == last) begin
          cnt_d = '0;
          sh_d  = {s_line, sh_q[7:1]};
          if (bit_q == 3'd7) st_d = RX_STOP;
          else bit_d = bit_q + 3'd1;
        end else begin
          cnt_d = cnt_q + DIV_W'(1);
        end
      end
      RX_STOP: begin
        if (cnt_q == last) begin
          cnt_d = '0;
          if (s_line) begin
            vld_d = 1'b1;
            st_d  = RX_IDLE;
          end else begin
            st_d = RX_BREAK;
          end
        end else begin
          cnt_d = cnt_q + DIV_W'(1);
        end
      end
      RX_BREAK: begin
        if (s_line) st_d = RX_IDLE;
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      vld_o  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], line_i};
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      vld_o  <= vld_d;
    end
  end

  assign data_o = sh_q;

endmodule

// File: rtl/dwb_uart_tx.sv
module dwb_uart_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             start_i,
  input  logic [7:0]       data_i,
  output logic             done_o,
  output logic             txd_o
);

  localparam int FRAME_W = 10;
  localparam int NB_W    = $clog2(FRAME_W);

  logic               busy_q, busy_d;
  logic [DIV_W-1:0]   cnt_q, cnt_d;
  logic [NB_W-1:0]    n_q, n_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               done_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    n_d    = n_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        sh_d   = {1'b1, data_i, 1'b0};
        cnt_d  = '0;
        n_d    = '0;
      end
    end else if (cnt_q == div - DIV_W'(1)) begin
      cnt_d = '0;
      sh_d  = {1'b1, sh_q[FRAME_W-1:1]};
      if (n_q == NB_W'(FRAME_W - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        n_d = n_q + NB_W'(1);
      end
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      n_q    <= '0;
      sh_q   <= '1;
      done_o <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      n_q    <= n_d;
      sh_q   <= sh_d;
      done_o <= done_d;
    end
  end

  assign txd_o = busy_q ? sh_q[0] : 1'b1;

endmodule

// File: rtl/dwb_seq.sv
module dwb_seq
  import dwb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DIV_W   = 16,
  parameter int BLK_MAX = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              rx_vld,
  input  logic [7:0]        rx_data,
  output logic              tx_start,
  output logic [7:0]        tx_data,
  input  logic              tx_done,
  output logic              drive_o,
  output logic              bus_req,
  output logic              bus_we,
  output logic [1:0]        bus_space,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata,
  input  logic              bus_ack
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int AB_W       = $clog2(ADDR_BYTES);
  localparam int CNT_W      = $clog2(BLK_MAX + 1);
  localparam int LFLD_W     = $clog2(BLK_MAX);
  localparam int TC_W       = DIV_W + 1;

  seq_state_e        st_q, st_d;
  logic              hold_v_q, hold_v_d;
  logic [7:0]        hold_q, hold_d;
  logic              take;
  logic              rd_q, rd_d;
  space_e            sp_q, sp_d;
  logic [CNT_W-1:0]  len_q, len_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  cnt_inc;
  logic [AB_W-1:0]   ab_q, ab_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        wdat_q, wdat_d;
  logic [TC_W-1:0]   tc_q, tc_d;
  logic [TC_W-1:0]   turn_lim;
  logic [7:0]        txd_q, txd_d;
  logic              start_d;
  logic              rsvd;
  logic [LFLD_W-1:0] lfld;
  size_e             sz;

  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign turn_lim = {1'b0, div} + {2'b00, div[DIV_W-1:1]};
  assign rsvd     = (sp_q == SP_RSVD);
  assign lfld     = hold_q[LFLD_W-1:0];
  assign sz       = size_e'(hold_q[6:5]);

  // holding slot for one received byte
  assign hold_v_d = rx_vld | (hold_v_q & ~take);
  assign hold_d   = rx_vld ? rx_data : hold_q;

  always_comb begin
    st_d    = st_q;
    take    = 1'b0;
    rd_d    = rd_q;
    sp_d    = sp_q;
    len_d   = len_q;
    cnt_d   = cnt_q;
    ab_d    = ab_q;
    addr_d  = addr_q;
    wdat_d  = wdat_q;
    tc_d    = tc_q;
    txd_d   = txd_q;
    start_d = 1'b0;
    case (st_q)
      SQ_CMD: begin
        if (hold_v_q) begin
          take  = 1'b1;
          rd_d  = hold_q[7];
          sp_d  = space_e'(hold_q[4:3]);
          cnt_d = '0;
          ab_d  = '0;
          case (sz)
            SZ_ONE:  len_d = CNT_W'(1);
            SZ_TWO:  len_d = CNT_W'(2);
            SZ_FOUR: len_d = CNT_W'(4);
            default: len_d = '0;
          endcase
          st_d = (sz == SZ_BLK) ? SQ_LEN : SQ_ADDR;
        end
      end
      SQ_LEN: begin
        if (hold_v_q) begin
          take  = 1'b1;
          len_d = (lfld == '0) ? CNT_W'(BLK_MAX) : CNT_W'(lfld);
          st_d  = SQ_ADDR;
        end
      end
      SQ_ADDR: begin
        if (hold_v_q) begin
          take   = 1'b1;
          addr_d = {hold_q, addr_q[ADDR_W-1:8]};
          ab_d   = ab_q + AB_W'(1);
          tc_d   = '0;
          if (ab_q == AB_W'(ADDR_BYTES - 1)) st_d = rd_q ? SQ_TURN : SQ_WDAT;
        end
      end
      SQ_WDAT: begin
        if (hold_v_q) begin
          take   = 1'b1;
          wdat_d = hold_q;
          st_d   = SQ_WBUS;
        end
      end
      SQ_WBUS: begin
        if (rsvd || bus_ack) begin
          addr_d = addr_q + ADDR_W'(1);
          cnt_d  = cnt_inc;
          st_d   = (cnt_inc == len_q) ? SQ_CMD : SQ_WDAT;
        end
      end
      SQ_TURN: begin
        if (tc_q == turn_lim) st_d = SQ_RBUS;
        else tc_d = tc_q + TC_W'(1);
      end
      SQ_RBUS: begin
        if (rsvd) begin
          txd_d   = 8'h00;
          start_d = 1'b1;
          st_d    = SQ_TX;
        end else if (bus_ack) begin
          txd_d   = bus_rdata;
          start_d = 1'b1;
          st_d    = SQ_TX;
        end
      end
      SQ_TX: begin
        if (tx_done) begin
          addr_d = addr_q + ADDR_W'(1);
          cnt_d  = cnt_inc;
          st_d   = (cnt_inc == len_q) ? SQ_CMD : SQ_RBUS;
        end
      end
      default: st_d = SQ_CMD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_CMD;
      hold_v_q <= 1'b0;
      hold_q   <= '0;
      rd_q     <= 1'b0;
      sp_q     <= SP_PERIPH;
      len_q    <= '0;
      cnt_q    <= '0;
      ab_q     <= '0;
      addr_q   <= '0;
      wdat_q   <= '0;
      tc_q     <= '0;
      txd_q    <= '0;
      tx_start <= 1'b0;
    end else begin
      st_q     <= st_d;
      hold_v_q <= hold_v_d;
      hold_q   <= hold_d;
      rd_q     <= rd_d;
      sp_q     <= sp_d;
      len_q    <= len_d;
      cnt_q    <= cnt_d;
      ab_q     <= ab_d;
      addr_q   <= addr_d;
      wdat_q   <= wdat_d;
      tc_q     <= tc_d;
      txd_q    <= txd_d;
      tx_start <= start_d;
    end
  end

  assign tx_data   = txd_q;
  assign drive_o   = (st_q == SQ_RBUS) || (st_q == SQ_TX);
  assign bus_req   = ((st_q == SQ_WBUS) || (st_q == SQ_RBUS)) && !rsvd;
  assign bus_we    = (st_q == SQ_WBUS);
  assign bus_space = sp_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdat_q;

endmodule

// File: rtl/dwb_wire_bridge.sv
module dwb_wire_bridge #(
  parameter int ADDR_W  = 32,
  parameter int DIV_W   = 16,
  parameter int BLK_MAX = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              bus_req,
  output logic              bus_we,
  output logic [1:0]        bus_space,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata,
  input  logic              bus_ack
);

  logic       rx_line;
  logic       rx_vld;
  logic [7:0] rx_data;
  logic       tx_start;
  logic [7:0] tx_data;
  logic       tx_done;

  // own transmission is not fed back into the receiver
  assign rx_line = pin_oe ? 1'b1 : pin_in;

  dwb_uart_rx #(.DIV_W(DIV_W), .SYNC_N(2)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .div    (baud_div),
    .line_i (rx_line),
    .vld_o  (rx_vld),
    .data_o (rx_data)
  );

  dwb_uart_tx #(.DIV_W(DIV_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .div     (baud_div),
    .start_i (tx_start),
    .data_i  (tx_data),
    .done_o  (tx_done),
    .txd_o   (pin_out)
  );

  dwb_seq #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .BLK_MAX(BLK_MAX)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .div       (baud_div),
    .rx_vld    (rx_vld),
    .rx_data   (rx_data),
    .tx_start  (tx_start),
    .tx_data   (tx_data),
    .tx_done   (tx_done),
    .drive_o   (pin_oe),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_space (bus_space),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack)
  );

endmodule

// File: rtl/dwb_wire_bridge_chk.sv
module dwb_wire_bridge_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pin_out,
  input logic              pin_oe,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_ack,
  input logic [1:0]        bus_space,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                            && $stable(bus_space) && $stable(bus_wdata)); // R6

  AST_NO_RSVD_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_space != 2'b11); // R10

  AST_QUIET_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> !pin_oe); // R9

  AST_READ_AFTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we |-> pin_oe); // R8

  AST_RELEASED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> pin_out); // R12

endmodule

bind dwb_wire_bridge dwb_wire_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_ack   (bus_ack),
  .bus_space (bus_space),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/sim_dwb_wire_bridge.sv
`timescale 1ns/1ps
module sim_dwb_wire_bridge;

  logic        clk;
  logic        rst_n;
  logic [15:0] baud_div;
  logic        pin_in;
  logic        pin_out;
  logic        pin_oe;
  logic        bus_req;
  logic        bus_we;
  logic [1:0]  bus_space;
  logic [31:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        bus_ack;

  logic        host_line;
  logic        host_drv;
  int          bdiv;
  int          checks;
  int          failures;
  int          cyc;
  int          sdelay;
  int          wcnt;
  int          stop_end_cyc;
  int          oe_rise_cyc;
  int          oe_falls;
  logic        oe_prev;
  logic [7:0]  smem [0:2][0:255];
  logic [7:0]  emem [0:2][0:255];
  logic [7:0]  wbuf [0:63];
  logic [42:0] expq [$];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign baud_div  = bdiv[15:0];
  assign pin_in    = pin_oe ? pin_out : host_line;
  assign bus_rdata = (bus_space == 2'b11) ? 8'h00 : smem[bus_space][bus_addr[7:0]];

  dwb_wire_bridge u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_div  (baud_div),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_space (bus_space),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // behavioural bus slave with programmable latency
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      bus_ack <= 1'b0;
      wcnt = 0;
    end else if (bus_req && !bus_ack) begin
      if (wcnt >= sdelay) begin
        bus_ack <= 1'b1;
        wcnt = 0;
        if (bus_we && bus_space != 2'b11) smem[bus_space][bus_addr[7:0]] = bus_wdata;
      end else begin
        wcnt = wcnt + 1;
      end
    end else begin
      bus_ack <= 1'b0;
    end
  end

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (rst_n) begin
      if (pin_oe && host_drv) chk(1'b0, "R9", "line contention", 1, 0);
      if (pin_oe && !oe_prev) oe_rise_cyc = cyc;
      if (!pin_oe && oe_prev) oe_falls++;
      if (bus_req && bus_ack) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R10", "unexpected bus access addr", int'(bus_addr), 0);
        end else begin
          logic [42:0] e;
          logic [42:0] g;
          e = expq.pop_front();
          g = {bus_we, bus_space, bus_addr, bus_we ? bus_wdata : 8'h00};
          chk(g == e, "R5", "bus access {we,space,addr,wdata}", int'(g[39:8]) ^ int'(g[7:0]), int'(e[39:8]) ^ int'(e[7:0]));
          chk(g[42:40] == e[42:40], "R3", "bus direction/space", int'(g[42:40]), int'(e[42:40]));
        end
      end
    end
    oe_prev = pin_oe;
  end

  task automatic send_byte(input logic [7:0] b, input logic stopv);
    @(negedge clk);
    host_drv  = 1'b1;
    host_line = 1'b0;
    repeat (bdiv) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      host_line = b[i];
      repeat (bdiv) @(negedge clk);
    end
    host_line = stopv;
    repeat (bdiv - 1) @(negedge clk);
    stop_end_cyc = cyc + 1;
    @(negedge clk);
    host_line = 1'b1;
    host_drv  = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b);
    while (!(pin_oe && !pin_out)) @(negedge clk);
    repeat (bdiv / 2) @(negedge clk);
    chk(pin_out == 1'b0, "R1", "start bit at mid-bit", int'(pin_out), 0);
    for (int i = 0; i < 8; i++) begin
      repeat (bdiv) @(negedge clk);
      b[i] = pin_out;
    end
    repeat (bdiv) @(negedge clk);
    chk(pin_out == 1'b1 && pin_oe, "R1", "driven stop bit", int'(pin_out), 1);
  endtask

  task automatic txn(input bit rd, input logic [1:0] sz, input logic [1:0] sp,
                     input logic [7:0] lenb, input logic [31:0] a, input int n, input string tag);
    logic [7:0] cmd;
    logic [7:0] got;
    logic [7:0] expb;
    logic [7:0] ix;
    int         f0;
    cmd = {rd, sz, sp, 3'b101};
    for (int i = 0; i < n; i++) begin
      if (sp != 2'b11) expq.push_back({~rd, sp, a + 32'(i), rd ? 8'h00 : wbuf[i]});
    end
    send_byte(cmd, 1'b1);
    if (sz == 2'b11) send_byte(lenb, 1'b1);
    for (int k = 0; k < 4; k++) send_byte(a[8*k +: 8], 1'b1);
    if (!rd) begin
      for (int i = 0; i < n; i++) begin
        ix = a[7:0] + 8'(i);
        if (sp != 2'b11) emem[sp][ix] = wbuf[i];
        send_byte(wbuf[i], 1'b1);
      end
      repeat (sdelay + 40) @(negedge clk);
      for (int i = 0; i < n; i++) begin
        ix = a[7:0] + 8'(i);
        if (sp != 2'b11) chk(smem[sp][ix] == wbuf[i], tag, "stored byte", int'(smem[sp][ix]), int'(wbuf[i]));
      end
      chk(!pin_oe, "R9", "line released during write", int'(pin_oe), 0);
    end else begin
      f0 = oe_falls;
      for (int i = 0; i < n; i++) begin
        ix   = a[7:0] + 8'(i);
        expb = (sp == 2'b11) ? 8'h00 : emem[sp][ix];
        recv_byte(got);
        if (i == 0)
          chk(oe_rise_cyc - stop_end_cyc >= bdiv && oe_rise_cyc - stop_end_cyc <= 2 * bdiv,
              "R8", "turnaround cycles", oe_rise_cyc - stop_end_cyc, bdiv);
        chk(got == expb, tag, "returned byte", int'(got), int'(expb));
      end
      repeat (bdiv) @(negedge clk);
      chk(!pin_oe, "R9", "line released after reply", int'(pin_oe), 0);
      chk(oe_falls == f0 + 1, "R9", "drive gaps in reply", oe_falls - f0, 1);
    end
    chk(expq.size() == 0, "R5", "pending expected accesses", expq.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0; cyc = 0; oe_falls = 0; oe_prev = 1'b0;
    stop_end_cyc = 0; oe_rise_cyc = 0; wcnt = 0;
    sdelay = 2; bdiv = 50;
    host_line = 1'b1; host_drv = 1'b0;
    for (int s = 0; s < 3; s++)
      for (int j = 0; j < 256; j++) begin
        smem[s][j] = 8'(j * 7 + s * 29 + 3);
        emem[s][j] = smem[s][j];
      end
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(!pin_oe, "R12", "oe in reset", int'(pin_oe), 0);
    chk(pin_out, "R12", "pin_out in reset", int'(pin_out), 1);
    chk(!bus_req, "R12", "req in reset", int'(bus_req), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!pin_oe && pin_out && !bus_req, "R12", "idle after reset", int'(pin_oe), 0);

    // one megabaud at 50 MHz
    wbuf[0] = 8'hA5;
    txn(1'b0, 2'b00, 2'b00, 8'h00, 32'h1234_5678, 1, "R3");
    txn(1'b1, 2'b01, 2'b01, 8'h00, 32'h0000_0010, 2, "R7");

    bdiv = 20;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    txn(1'b0, 2'b10, 2'b10, 8'h00, 32'h0000_0020, 4, "R5");
    txn(1'b1, 2'b10, 2'b10, 8'h00, 32'h0000_0020, 4, "R5");
    for (int i = 0; i < 8; i++) wbuf[i] = 8'(8'hC0 + i);
    txn(1'b0, 2'b11, 2'b01, 8'h08, 32'h0000_0040, 8, "R4");
    txn(1'b1, 2'b11, 2'b01, 8'h00, 32'h0000_0080, 64, "R4");
    txn(1'b1, 2'b11, 2'b00, 8'h45, 32'h0000_00FE, 5, "R4");

    // reserved space
    wbuf[0] = 8'h5A;
    txn(1'b0, 2'b00, 2'b11, 8'h00, 32'h0000_0001, 1, "R10");
    txn(1'b1, 2'b10, 2'b11, 8'h00, 32'h0000_0001, 4, "R10");

    // framing error: bad character then a valid write
    send_byte(8'b1000_0000, 1'b0);
    repeat (2 * bdiv) @(negedge clk);
    wbuf[0] = 8'h3C;
    txn(1'b0, 2'b00, 2'b01, 8'h00, 32'h0000_0005, 1, "R2");
    txn(1'b1, 2'b00, 2'b01, 8'h00, 32'h0000_0005, 1, "R2");

    // acknowledge latency swept around one character time
    for (int d = -4; d <= 3; d++) begin
      sdelay = 10 * bdiv + d;
      for (int i = 0; i < 4; i++) wbuf[i] = 8'((d + 8) * 16 + i);
      txn(1'b0, 2'b11, 2'b00, 8'h04, 32'h0000_0060 + 32'((d + 4) * 4), 4, "R11");
    end
    sdelay = 2;

    repeat (20) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule